// File: doc/BRIEF.md
# Bit-Serial Half-Precision Floating-Point Adder

This block adds two half-precision floating-point numbers that arrive one bit per clock. Each operand uses two serial lines. One carries the 11-bit significand with its hidden bit. The other carries a 6-bit sign/exponent field. Both lines are least-significant bit first. A one-cycle start strobe marks bit 0, and both lines of both operands start on that same cycle.

Inside, the work happens in three ordered steps. First the operand with the smaller magnitude is shifted right to the larger exponent, and it is rounded to nearest-even during that shift. Next the two significands are added or subtracted, as the signs select. Last the result is normalized and its exponent is adjusted. The sum leaves on the same two-line serial format, with its own start strobe and a valid strobe. It appears a fixed number of cycles after the input start.

A new operand pair may start every 20 cycles. Operands are assumed to be normal numbers: exponent 1 to 30 and the hidden bit set. Subnormal, infinity and NaN encodings are not given any special handling.

Top module: `bsfp_adder`

## Requirements
- R1: The serial format is the same for inputs and output, least-significant bit first, with bit 0 on the cycle of the start strobe. The significand line carries 11 bits, and bit 10 is the hidden bit. The sign/exponent line carries the biased exponent in bits 0 to 4 and the sign in bit 5. The input sign/exponent line is ignored in bit positions 6 to 10. On the output, `out_vld` is high for exactly the 11 bit cycles of a word, `out_se` is 0 in positions 6 to 10, and both data outputs are 0 whenever `out_vld` is low.
- R2: `out_sop` is high in the cycle that follows the 13th rising edge after the edge that samples `in_sop`. That cycle carries result bit 0.
- R3: The operand with the larger magnitude is the reference. Magnitude is compared on the exponent first, then on the significand, and a tie picks operand A. The result sign is the reference operand's sign, except in the cases of R8.
- R4: The smaller operand is shifted right by the exponent difference and rounded to nearest-even. The first shifted-out bit acts as the guard bit, and the OR of all lower shifted-out bits acts as the sticky bit. The kept value is incremented when guard is 1 and either sticky is 1 or the kept LSB is 1.
- R5: When the exponent difference is 12 or more, the smaller operand adds nothing to the significand sum. The result equals the reference operand.
- R6: The rounded significands are added when the signs are equal and subtracted (reference minus smaller) when they differ.
- R7: A carry out of the 11-bit sum shifts the significand right by one, dropping its LSB, and adds 1 to the exponent. A sum without carry is shifted left until bit 10 is set, and the exponent is reduced by the shift count.
- R8: A sum of exactly zero gives +0: sign 0, exponent 0, significand 0.
- R9: A normalized exponent above 30 saturates to the largest finite value: exponent 30 and significand 2047, with the result sign kept.
- R10: A normalized exponent below 1 flushes to zero: exponent 0 and significand 0, with the result sign kept.
- R11: Pairs that start exactly 20 cycles apart each produce their own correct result, 20 cycles apart, with no carry-over between words.
- R12: While reset is high, and on the cycle after it, `out_sop`, `out_vld`, `out_sig` and `out_se` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | Start strobe, high on bit 0 of both operands |
| a_sig | input | 1 | Operand A significand serial line |
| a_se | input | 1 | Operand A sign/exponent serial line |
| b_sig | input | 1 | Operand B significand serial line |
| b_se | input | 1 | Operand B sign/exponent serial line |
| out_sop | output | 1 | Result start strobe, high on result bit 0 |
| out_vld | output | 1 | High during the 11 bit cycles of a result |
| out_sig | output | 1 | Result significand serial line |
| out_se | output | 1 | Result sign/exponent serial line |

## Verification
Directed pairs cover several paths. Equal-exponent same-sign sums take the carry-out path. Exact ties at a difference of one, with an even and an odd kept LSB, separate round-to-even from round-half-up. An above-half remainder at a difference of two gives a plain round-up. Differences of 12 and 13 show that a far operand leaves the sum unchanged. Opposite-sign pairs with the smaller operand on either input check operand swapping and the result sign. Equal magnitudes give +0, and a subtraction whose rounding carries into a cancellation also gives zero. Top-exponent and bottom-exponent pairs drive saturation and flush. About 150 random normal pairs, sent back to back at the 20-cycle spacing, check the general path and that no state carries from one word to the next.

// File: rtl/bsfp_pkg.sv
package bsfp_pkg;

  localparam int SIG_W_DEF = 11;
  localparam int EXP_W_DEF = 5;

  // result classes chosen by the normalizer
  typedef enum logic [2:0] {
    NC_ZERO  = 3'd0,
    NC_RIGHT = 3'd1,
    NC_LEFT  = 3'd2,
    NC_OVF   = 3'd3,
    NC_UNF   = 3'd4
  } norm_case_e;

  // largest biased exponent of a finite number
  function automatic int exp_max(input int ew);
    return (1 << ew) - 2;
  endfunction

endpackage

// File: rtl/bsfp_deser.sv
module bsfp_deser #(
  parameter int SIG_W = 11,
  parameter int SE_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sop,
  input  logic             sig_bit,
  input  logic             se_bit,
  output logic [SIG_W-1:0] sig_word,
  output logic [SE_W-1:0]  se_word,
  output logic             word_done
);
  localparam int IDX_W = $clog2(SIG_W + 1);

  logic [IDX_W-1:0] idx;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      active    <= 1'b0;
      word_done <= 1'b0;
      sig_word  <= '0;
      se_word   <= '0;
    end else begin
      word_done <= 1'b0;
      if (sop) begin
        sig_word <= {sig_bit, sig_word[SIG_W-1:1]};
        se_word  <= {se_bit, se_word[SE_W-1:1]};
        idx      <= IDX_W'(1);
        active   <= 1'b1;
      end else if (active) begin
        sig_word <= {sig_bit, sig_word[SIG_W-1:1]};
        if (idx < IDX_W'(SE_W))
          se_word <= {se_bit, se_word[SE_W-1:1]};
        if (idx == IDX_W'(SIG_W - 1)) begin
          active    <= 1'b0;
          word_done <= 1'b1;
        end
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bsfp_align.sv
module bsfp_align #(
  parameter int SIG_W = 11,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [SIG_W-1:0] sig_a,
  input  logic [EXP_W:0]   se_a,
  input  logic [SIG_W-1:0] sig_b,
  input  logic [EXP_W:0]   se_b,
  output logic             al_vld,
  output logic [SIG_W-1:0] big_sig,
  output logic [SIG_W:0]   sml_rnd,
  output logic [EXP_W-1:0] big_exp,
  output logic             res_sign,
  output logic             eff_sub
);
  localparam int XW   = 2 * SIG_W + 1;
  localparam int SH_W = $clog2(SIG_W + 2);
  localparam int SH_MAX = SIG_W + 1;

  logic             a_big;
  logic [EXP_W-1:0] ea, eb, e_big, e_sml, d;
  logic [SIG_W-1:0] s_big, s_sml, kept;
  logic [SH_W-1:0]  dcl;
  logic [XW-1:0]    ext, shifted;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   rnd;

  always_comb begin
    ea    = se_a[EXP_W-1:0];
    eb    = se_b[EXP_W-1:0];
    a_big = (ea > eb) || ((ea == eb) && (sig_a >= sig_b));
    e_big = a_big ? ea : eb;
    e_sml = a_big ? eb : ea;
    s_big = a_big ? sig_a : sig_b;
    s_sml = a_big ? sig_b : sig_a;
    d     = e_big - e_sml;
    dcl   = (int'(d) > SH_MAX) ? SH_W'(SH_MAX) : SH_W'(d);
    ext     = {s_sml, {(SIG_W + 1){1'b0}}};
    shifted = ext >> dcl;
    kept    = shifted[XW-1 -: SIG_W];
    guard   = shifted[SIG_W];
    sticky  = |shifted[SIG_W-1:0];
    inc     = guard & (sticky | kept[0]);
    rnd     = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_vld   <= 1'b0;
      big_sig  <= '0;
      sml_rnd  <= '0;
      big_exp  <= '0;
      res_sign <= 1'b0;
      eff_sub  <= 1'b0;
    end else begin
      al_vld <= in_vld;
      if (in_vld) begin
        big_sig  <= s_big;
        sml_rnd  <= rnd;
        big_exp  <= e_big;
        res_sign <= a_big ? se_a[EXP_W] : se_b[EXP_W];
        eff_sub  <= se_a[EXP_W] ^ se_b[EXP_W];
      end
    end
  end
endmodule

// File: rtl/bsfp_addnorm.sv
module bsfp_addnorm
  import bsfp_pkg::*;
#(
  parameter int SIG_W = 11,
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             al_vld,
  input  logic [SIG_W-1:0] big_sig,
  input  logic [SIG_W:0]   sml_rnd,
  input  logic [EXP_W-1:0] big_exp,
  input  logic             res_sign,
  input  logic             eff_sub,
  output logic             res_vld,
  output logic [SIG_W-1:0] res_sig,
  output logic [EXP_W:0]   res_se
);
  localparam int EMAX = exp_max(EXP_W);

  logic [SIG_W:0]   mag;
  logic [SIG_W-1:0] left_sig;
  int               lz;
  int               e_up, e_dn;
  norm_case_e       nc;

  always_comb begin
    mag = eff_sub ? ({1'b0, big_sig} - sml_rnd) : ({1'b0, big_sig} + sml_rnd);
    lz  = SIG_W;
    for (int i = 0; i < SIG_W; i++)
      if (mag[i]) lz = SIG_W - 1 - i;
    left_sig = mag[SIG_W-1:0] << lz;
    e_up = int'(big_exp) + 1;
    e_dn = int'(big_exp) - lz;
    if (mag == '0)          nc = NC_ZERO;
    else if (mag[SIG_W])    nc = (e_up > EMAX) ? NC_OVF : NC_RIGHT;
    else if (e_dn < 1)      nc = NC_UNF;
    else                    nc = NC_LEFT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld <= 1'b0;
      res_sig <= '0;
      res_se  <= '0;
    end else begin
      res_vld <= al_vld;
      if (al_vld) begin
        unique case (nc)
          NC_ZERO: begin
            res_sig <= '0;
            res_se  <= '0;
          end
          NC_RIGHT: begin
            res_sig <= mag[SIG_W:1];
            res_se  <= {res_sign, EXP_W'(e_up)};
          end
          NC_OVF: begin
            res_sig <= '1;
            res_se  <= {res_sign, EXP_W'(EMAX)};
          end
          NC_UNF: begin
            res_sig <= '0;
            res_se  <= {res_sign, {EXP_W{1'b0}}};
          end
          default: begin
            res_sig <= left_sig;
            res_se  <= {res_sign, EXP_W'(e_dn)};
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bsfp_ser.sv
module bsfp_ser #(
  parameter int SIG_W = 11,
  parameter int SE_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SIG_W-1:0] sig_w,
  input  logic [SE_W-1:0]  se_w,
  output logic             out_sop,
  output logic             out_vld,
  output logic             out_sig,
  output logic             out_se
);
  localparam int CNT_W = $clog2(SIG_W);

  logic [SIG_W-1:0] sig_sh;
  logic [SE_W-1:0]  se_sh;
  logic [CNT_W-1:0] left_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_sh   <= '0;
      se_sh    <= '0;
      left_cnt <= '0;
      out_sop  <= 1'b0;
      out_vld  <= 1'b0;
      out_sig  <= 1'b0;
      out_se   <= 1'b0;
    end else if (load) begin
      out_sop  <= 1'b1;
      out_vld  <= 1'b1;
      out_sig  <= sig_w[0];
      out_se   <= se_w[0];
      sig_sh   <= sig_w >> 1;
      se_sh    <= se_w >> 1;
      left_cnt <= CNT_W'(SIG_W - 1);
    end else if (left_cnt != '0) begin
      out_sop  <= 1'b0;
      out_vld  <= 1'b1;
      out_sig  <= sig_sh[0];
      out_se   <= se_sh[0];
      sig_sh   <= sig_sh >> 1;
      se_sh    <= se_sh >> 1;
      left_cnt <= left_cnt - 1'b1;
    end else begin
      out_sop <= 1'b0;
      out_vld <= 1'b0;
      out_sig <= 1'b0;
      out_se  <= 1'b0;
    end
  end
endmodule

// File: rtl/bsfp_adder.sv
module bsfp_adder
  import bsfp_pkg::*;
#(
  parameter int SIG_W = SIG_W_DEF,
  parameter int EXP_W = EXP_W_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic in_sop,
  input  logic a_sig,
  input  logic a_se,
  input  logic b_sig,
  input  logic b_se,
  output logic out_sop,
  output logic out_vld,
  output logic out_sig,
  output logic out_se
);
  localparam int SE_W  = EXP_W + 1;
  localparam int N_OPS = 2;

  logic [N_OPS-1:0]            sig_lines, se_lines, done_v;
  logic [N_OPS-1:0][SIG_W-1:0] sig_words;
  logic [N_OPS-1:0][SE_W-1:0]  se_words;
  logic                        words_rdy;

  assign sig_lines = {b_sig, a_sig};
  assign se_lines  = {b_se, a_se};

  for (genvar g = 0; g < N_OPS; g++) begin : g_in
    bsfp_deser #(.SIG_W(SIG_W), .SE_W(SE_W)) deser_i (
      .clk      (clk),
      .rst      (rst),
      .sop      (in_sop),
      .sig_bit  (sig_lines[g]),
      .se_bit   (se_lines[g]),
      .sig_word (sig_words[g]),
      .se_word  (se_words[g]),
      .word_done(done_v[g])
    );
  end

  assign words_rdy = &done_v;

  logic             al_vld, res_sign, eff_sub;
  logic [SIG_W-1:0] big_sig;
  logic [SIG_W:0]   sml_rnd;
  logic [EXP_W-1:0] big_exp;

  bsfp_align #(.SIG_W(SIG_W), .EXP_W(EXP_W)) align_i (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (words_rdy),
    .sig_a   (sig_words[0]),
    .se_a    (se_words[0]),
    .sig_b   (sig_words[1]),
    .se_b    (se_words[1]),
    .al_vld  (al_vld),
    .big_sig (big_sig),
    .sml_rnd (sml_rnd),
    .big_exp (big_exp),
    .res_sign(res_sign),
    .eff_sub (eff_sub)
  );

  logic             core_vld;
  logic [SIG_W-1:0] core_sig;
  logic [SE_W-1:0]  core_se;

  bsfp_addnorm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) addnorm_i (
    .clk     (clk),
    .rst     (rst),
    .al_vld  (al_vld),
    .big_sig (big_sig),
    .sml_rnd (sml_rnd),
    .big_exp (big_exp),
    .res_sign(res_sign),
    .eff_sub (eff_sub),
    .res_vld (core_vld),
    .res_sig (core_sig),
    .res_se  (core_se)
  );

  bsfp_ser #(.SIG_W(SIG_W), .SE_W(SE_W)) ser_i (
    .clk    (clk),
    .rst    (rst),
    .load   (core_vld),
    .sig_w  (core_sig),
    .se_w   (core_se),
    .out_sop(out_sop),
    .out_vld(out_vld),
    .out_sig(out_sig),
    .out_se (out_se)
  );
endmodule

// File: rtl/bsfp_adder_chk.sv
module bsfp_adder_chk
  import bsfp_pkg::*;
#(
  parameter int SIG_W = 11,
  parameter int EXP_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_sop,
  input logic             out_sop,
  input logic             out_vld,
  input logic             out_sig,
  input logic             out_se,
  input logic             res_vld,
  input logic [SIG_W-1:0] res_sig,
  input logic [EXP_W:0]   res_se
);
  localparam int LAT  = SIG_W + 2;
  localparam int SE_W = EXP_W + 1;
  localparam int EMAX = exp_max(EXP_W);

  logic [LAT:0] sop_pipe;
  int           vcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sop_pipe <= '0;
      vcnt     <= 0;
    end else begin
      sop_pipe <= {sop_pipe[LAT-1:0], in_sop};
      vcnt     <= out_vld ? vcnt + 1 : 0;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_sop == sop_pipe[LAT]);

  p_sop_first_r1: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> (out_vld && vcnt == 0));

  p_word_len_r1: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && vcnt != 0) |-> (vcnt == SIG_W));

  p_se_pad_r1: assert property (@(posedge clk) disable iff (rst)
    (out_vld && vcnt >= SE_W) |-> !out_se);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (!out_sig && !out_se));

  p_normalized_r7: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_se[EXP_W-1:0] != '0) |-> res_sig[SIG_W-1]);

  p_zero_sig_r8: assert property (@(posedge clk) disable iff (rst)
    (res_vld && res_se[EXP_W-1:0] == '0) |-> (res_sig == '0));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> (int'(res_se[EXP_W-1:0]) <= EMAX));

  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> (!out_vld && !out_sop));
endmodule

bind bsfp_adder bsfp_adder_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .in_sop (in_sop),
  .out_sop(out_sop),
  .out_vld(out_vld),
  .out_sig(out_sig),
  .out_se (out_se),
  .res_vld(core_vld),
  .res_sig(core_sig),
  .res_se (core_se)
);

// File: tb/bsfp_adder_tb_top.sv
`timescale 1ns/1ps
module bsfp_adder_tb_top;
  localparam int LAT   = 13;
  localparam int NCYC  = 8192;
  localparam int WD_NS = 4 * 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_sop = 1'b0, a_sig = 1'b0, a_se = 1'b0, b_sig = 1'b0, b_se = 1'b0;
  logic out_sop, out_vld, out_sig, out_se;

  always #2 clk = ~clk;

  bsfp_adder dut_i (
    .clk(clk), .rst(rst), .in_sop(in_sop),
    .a_sig(a_sig), .a_se(a_se), .b_sig(b_sig), .b_se(b_se),
    .out_sop(out_sop), .out_vld(out_vld), .out_sig(out_sig), .out_se(out_se)
  );

  typedef struct {
    int    sig;
    int    se;
    string tag;
  } wexp_t;

  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    mon_en = 0, finished = 0;
  bit    e_sop [NCYC], e_vld [NCYC], e_sig [NCYC], e_se [NCYC];
  wexp_t wq[$];
  int    bi = 0, cap_sig = 0, cap_se = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference arithmetic from the requirements
  task automatic ref_add(input int sa, ea, ma, sb, eb, mb, output int rs, re, rm);
    int bs, be, bm, ss, sm, d, kept, rem, half, mag;
    if (ea > eb || (ea == eb && ma >= mb)) begin
      bs = sa; be = ea; bm = ma; ss = sb; sm = mb; d = ea - eb;
    end else begin
      bs = sb; be = eb; bm = mb; ss = sa; sm = ma; d = eb - ea;
    end
    if (d == 0) kept = sm;
    else begin
      kept = sm >> d;
      rem  = sm - (kept << d);
      half = 1 << (d - 1);
      if (rem > half || (rem == half && (kept % 2) == 1)) kept = kept + 1;
    end
    mag = (bs != ss) ? bm - kept : bm + kept;
    if (mag == 0) begin
      rs = 0; re = 0; rm = 0;
    end else if (mag >= 2048) begin
      rs = bs; rm = mag / 2; re = be + 1;
      if (re > 30) begin re = 30; rm = 2047; end
    end else begin
      rs = bs; rm = mag; re = be;
      while (rm < 1024) begin rm = rm * 2; re = re - 1; end
      if (re < 1) begin re = 0; rm = 0; end
    end
  endtask

  task automatic send(input int sa, ea, ma, sb, eb, mb, input string tag);
    int rs, re, rm, start, sea, seb, rse;
    wexp_t w;
    sea = (sa << 5) | ea;
    seb = (sb << 5) | eb;
    ref_add(sa, ea, ma, sb, eb, mb, rs, re, rm);
    rse = (rs << 5) | re;
    @(negedge clk);
    start = cyc + 1;
    for (int i = 0; i < 11; i++) begin
      int k;
      k = start + LAT + i;
      e_vld[k] = 1'b1;
      e_sop[k] = (i == 0);
      e_sig[k] = ((rm >> i) & 1) != 0;
      e_se[k]  = (i < 6) ? (((rse >> i) & 1) != 0) : 1'b0;
    end
    w.sig = rm; w.se = rse; w.tag = tag;
    wq.push_back(w);
    for (int i = 0; i < 11; i++) begin
      if (i > 0) @(negedge clk);
      in_sop = (i == 0);
      a_sig  = ((ma >> i) & 1) != 0;
      b_sig  = ((mb >> i) & 1) != 0;
      // positions 6..10 of the sign/exponent line carry ones to show they are ignored (R1)
      a_se   = (i < 6) ? (((sea >> i) & 1) != 0) : 1'b1;
      b_se   = (i < 6) ? (((seb >> i) & 1) != 0) : 1'b1;
    end
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      in_sop = 0; a_sig = 0; b_sig = 0; a_se = 0; b_se = 0;
    end
  endtask

  // per-cycle comparison and word assembly
  always @(negedge clk) begin
    if (mon_en && !finished) begin
      n_chk++;
      if (out_sop !== e_sop[cyc] || out_vld !== e_vld[cyc] ||
          out_sig !== e_sig[cyc] || out_se !== e_se[cyc]) begin
        n_fail++;
        $display("FAIL R2 cycle %0d: sop/vld/sig/se = %b%b%b%b expected %b%b%b%b",
                 cyc, out_sop, out_vld, out_sig, out_se,
                 e_sop[cyc], e_vld[cyc], e_sig[cyc], e_se[cyc]);
      end
      if (out_vld) begin
        if (out_sop) begin bi = 0; cap_sig = 0; cap_se = 0; end
        if (out_sig) cap_sig = cap_sig | (1 << bi);
        if (out_se && bi < 6) cap_se = cap_se | (1 << bi);
        bi++;
        if (bi == 11) begin
          wexp_t w;
          n_chk++;
          if (wq.size() == 0) begin
            n_fail++;
            $display("FAIL R2 unexpected word sig=%0d se=%0d expected none", cap_sig, cap_se);
          end else begin
            w = wq.pop_front();
            if (cap_sig != w.sig || cap_se != w.se) begin
              n_fail++;
              $display("FAIL %s word sig=%0d sgn=%0d exp=%0d expected sig=%0d sgn=%0d exp=%0d",
                       w.tag, cap_sig, cap_se >> 5, cap_se & 31, w.sig, w.se >> 5, w.se & 31);
            end
          end
          bi = 0;
        end
      end
    end
  end

  task automatic chk_quiet(input string tag);
    n_chk++;
    if (out_sop !== 1'b0 || out_vld !== 1'b0 || out_sig !== 1'b0 || out_se !== 1'b0) begin
      n_fail++;
      $display("FAIL %s outputs sop/vld/sig/se = %b%b%b%b expected 0000",
               tag, out_sop, out_vld, out_sig, out_se);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_quiet("R12");
    rst = 1'b0;
    @(negedge clk);
    chk_quiet("R12");
    mon_en = 1'b1;

    // carry-out on same-sign equal exponents: R7, R6
    send(0, 15, 1024, 0, 15, 1024, "R7");
    send(1, 15, 2047, 1, 15, 1025, "R7");
    // tie at difference 1, even kept LSB stays: R4
    send(0, 10, 1024, 0, 9, 1025, "R4");
    // tie at difference 1, odd kept LSB rounds up: R4
    send(0, 10, 1024, 0, 9, 1027, "R4");
    // above-half remainder at difference 2: R4
    send(0, 10, 1100, 0, 8, 1027, "R4");
    // far operand contributes only sticky: R5
    send(0, 20, 1500, 0, 7, 2047, "R5");
    send(0, 20, 1024, 1, 8, 2047, "R5");
    // smaller operand on A, larger negative on B: R3
    send(0, 10, 1200, 1, 10, 1300, "R3");
    send(1, 9, 2000, 0, 12, 1111, "R3");
    // cancellation with left shift: R7, R6
    send(0, 16, 1030, 1, 15, 2040, "R6");
    // exact equal magnitudes give +0: R8
    send(1, 12, 1111, 0, 12, 1111, "R8");
    send(0, 12, 1111, 1, 12, 1111, "R8");
    // rounding during alignment cancels the sum: R8
    send(0, 15, 1024, 1, 14, 2047, "R8");
    // overflow saturates: R9
    send(1, 30, 2000, 1, 30, 1900, "R9");
    send(0, 30, 1024, 0, 29, 2047, "R9");
    // underflow flushes: R10
    send(1, 1, 1030, 0, 1, 1024, "R10");
    send(0, 2, 1024, 1, 1, 2044, "R10");
    // back-to-back random pairs at the 20-cycle spacing: R11
    for (int n = 0; n < 150; n++) begin
      send($urandom_range(1, 0), $urandom_range(30, 1), $urandom_range(2047, 1024),
           $urandom_range(1, 0), $urandom_range(30, 1), $urandom_range(2047, 1024), "R11");
    end

    repeat (40) @(negedge clk);
    n_chk++;
    if (wq.size() != 0) begin
      n_fail++;
      $display("FAIL R2 %0d words missing expected 0", wq.size());
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(WD_NS);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog expired at cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule